// File: doc/BRIEF.md
# Autovectored Interrupt Acceptance Unit

This unit sits on the processor side of a three-bit interrupt level input. A level of zero means no request. Levels one to seven are requests of rising priority. The unit samples the level and waits until the value has stayed the same for two samples. It then compares that level with the processor's current priority mask. When it accepts an interrupt, it switches the processor into supervisor mode and raises the mask to the accepted level. After that it runs a fixed acknowledge sequence to find where the handler lives.

The acknowledge sequence has four steps. First, the unit reads the level's own word among the seven highest words of the address space and keeps the low byte of that word as a vector number. Second, it asks an external agent to save the status and program counter, and waits until that agent reports done. Third, it reads a 32-bit handler address from a vector table entry. The entry address is the vector number times four, added to a relocatable base register. Fourth, it presents the handler address for one cycle as the new program counter.

Level seven is non-maskable and edge-triggered. Software can rewrite the mode and mask through a status write port, and can rewrite the base register only while in supervisor mode.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset the unit is in supervisor mode with priority mask 7. The vector base is 0, and busReq, stackReq and pcLoad are low.
- R2: A level is compared only after two consecutive samples agree. From the clock edge that first sees a new steady level, busReq rises on the third edge. A level that changes every cycle is never accepted.
- R3: When idle, a steady nonzero level below 7 is accepted only if it is strictly greater than priMask. A level of 0, or a level at or below priMask, leaves busReq low and priMask unchanged.
- R4: Level 7 is accepted whatever priMask is. While level 7 is held, it is accepted only once. It is accepted again only after the input has held a steady level other than 7.
- R5: The acknowledge read uses the address whose bits above bit 3 are all ones, whose bits [3:1] hold the accepted level, and whose bit 0 is zero. Bits [7:0] of the returned data are the vector number, and the upper data bits are ignored.
- R6: The vector read address equals the base register plus (vector number shifted left by two), computed modulo the address width.
- R7: On the acceptance edge, superMode becomes 1 and priMask becomes the accepted level.
- R8: The order is fixed: acknowledge read, then stackReq held until stackDone, then vector read, then exactly one cycle of pcLoad with pcValue equal to the 32-bit data of the vector read. busReq and stackReq are never high together.
- R9: Each read holds busReq high and busAddr stable until a cycle in which busReady is high. The data is taken in that cycle.
- R10: A base register write takes effect only while superMode is 1. In user mode it is ignored.
- R11: A status write sets superMode and priMask only while the unit is idle. During a sequence it is ignored. An acceptance in the same cycle takes priority over a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLevel | input | 3 | Incoming interrupt level, 0 = none |
| srWe | input | 1 | Status write strobe |
| srSuper | input | 1 | Mode value for a status write |
| srMask | input | 3 | Mask value for a status write |
| vbrWe | input | 1 | Base register write strobe |
| vbrWdata | input | 24 | Base register write value |
| busReq | output | 1 | Read request |
| busAddr | output | 24 | Read address |
| busRdata | input | 32 | Read data |
| busReady | input | 1 | Read completes this cycle |
| stackReq | output | 1 | Request to save status and program counter |
| stackDone | input | 1 | Save finished |
| pcLoad | output | 1 | One-cycle strobe to load the program counter |
| pcValue | output | 32 | Handler address to load |
| superMode | output | 1 | Supervisor mode flag |
| priMask | output | 3 | Current priority mask |

## Verification
The bench sweeps every pair of mask and level. A comparator using greater-or-equal, or one that let level 7 be masked, would start a sequence where none is due, or miss one that is due. The bench holds level 7 and then lowers the mask. An NMI that was level-triggered would restart the sequence over and over. A level that toggles every cycle must never start a sequence, and every accepted level must start with exactly three edges of latency. A missing or extra sampling stage shows up as a different count.

The bench puts junk in the upper byte of the acknowledge data. A design that shifted the wrong byte would then form an offset outside the autovector range. The bench also writes the base register while in user mode. A design that did not enforce the privilege rule would relocate the next vector read. Finally, the bench drives a status write during the save step. A design that accepted it would show a changed mask when pcLoad fires.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_STACK,
    ST_VEC,
    ST_LOAD
  } accState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       accept;   // acceptance edge: update mode and mask
    logic       ackDone;  // capture vector number
    logic       vecDone;  // capture handler address
    logic       selVec;   // drive vector address on the bus
    logic       idle;     // status writes allowed
    logic [2:0] level;    // level being accepted / served
  } accStrobe_t;

endpackage

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] irqLevel,
  input  logic [LVL_W-1:0] priMask,
  input  logic             busReady,
  input  logic             stackDone,
  output accStrobe_t       strb,
  output logic             busReq,
  output logic             stackReq,
  output logic             pcLoad
);

  localparam logic [LVL_W-1:0] NMI_LVL  = '1;
  localparam logic [LVL_W-1:0] NONE_LVL = '0;

  accState_t        state, stateNext;
  logic [LVL_W-1:0] sampA, sampB, lvlHold;
  logic             nmiArmed;
  logic             steady, nmiHit, maskHit, accept;

  assign steady  = (sampA == sampB);
  assign nmiHit  = (sampB == NMI_LVL) && nmiArmed;
  assign maskHit = (sampB != NMI_LVL) && (sampB != NONE_LVL) && (sampB > priMask);
  assign accept  = (state == ST_IDLE) && steady && (nmiHit || maskHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampA    <= '0;
      sampB    <= '0;
      nmiArmed <= 1'b1;
      lvlHold  <= '0;
    end else begin
      sampA <= irqLevel;
      sampB <= sampA;
      if (accept && (sampB == NMI_LVL))
        nmiArmed <= 1'b0;
      else if (steady && (sampB != NMI_LVL))
        nmiArmed <= 1'b1;
      if (accept)
        lvlHold <= sampB;
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (accept)    stateNext = ST_ACK;
      ST_ACK:   if (busReady)  stateNext = ST_STACK;
      ST_STACK: if (stackDone) stateNext = ST_VEC;
      ST_VEC:   if (busReady)  stateNext = ST_LOAD;
      ST_LOAD:                 stateNext = ST_IDLE;
      default:                 stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb.accept  = accept;
    strb.ackDone = (state == ST_ACK) && busReady;
    strb.vecDone = (state == ST_VEC) && busReady;
    strb.selVec  = (state == ST_VEC);
    strb.idle    = (state == ST_IDLE);
    strb.level   = accept ? sampB : lvlHold;
  end

  assign busReq   = (state == ST_ACK) || (state == ST_VEC);
  assign stackReq = (state == ST_STACK);
  assign pcLoad   = (state == ST_LOAD);

endmodule

// File: rtl/irq_accept_dpath.sv
module irq_accept_dpath
  import irq_accept_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int LVL_W  = 3,
  parameter int VNUM_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  accStrobe_t        strb,
  input  logic              srWe,
  input  logic              srSuper,
  input  logic [LVL_W-1:0]  srMask,
  input  logic              vbrWe,
  input  logic [ADDR_W-1:0] vbrWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] pcValue,
  output logic              superMode,
  output logic [LVL_W-1:0]  priMask
);

  localparam int OFS_W  = VNUM_W + 2;
  localparam int TOP_W  = ADDR_W - LVL_W - 1;

  logic [ADDR_W-1:0] vbrQ, ackAddr, vecOffset, vecAddr;
  logic [VNUM_W-1:0] vecNumQ;
  logic [DATA_W-1:0] handlerQ;
  logic              superQ;
  logic [LVL_W-1:0]  maskQ;

  assign ackAddr   = {{TOP_W{1'b1}}, strb.level, 1'b0};
  assign vecOffset = {{(ADDR_W-OFS_W){1'b0}}, vecNumQ, 2'b00};
  assign vecAddr   = vbrQ + vecOffset;
  assign busAddr   = strb.selVec ? vecAddr : ackAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      superQ <= 1'b1;
      maskQ  <= '1;
    end else if (strb.accept) begin
      superQ <= 1'b1;
      maskQ  <= strb.level;
    end else if (srWe && strb.idle) begin
      superQ <= srSuper;
      maskQ  <= srMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) vbrQ <= '0;
    else if (vbrWe && superQ) vbrQ <= vbrWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecNumQ  <= '0;
      handlerQ <= '0;
    end else begin
      if (strb.ackDone) vecNumQ  <= busRdata[VNUM_W-1:0];
      if (strb.vecDone) handlerQ <= busRdata;
    end
  end

  assign pcValue   = handlerQ;
  assign superMode = superQ;
  assign priMask   = maskQ;

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  irqLevel,
  input  logic        srWe,
  input  logic        srSuper,
  input  logic [2:0]  srMask,
  input  logic        vbrWe,
  input  logic [23:0] vbrWdata,
  output logic        busReq,
  output logic [23:0] busAddr,
  input  logic [31:0] busRdata,
  input  logic        busReady,
  output logic        stackReq,
  input  logic        stackDone,
  output logic        pcLoad,
  output logic [31:0] pcValue,
  output logic        superMode,
  output logic [2:0]  priMask
);

  accStrobe_t strb;

  irq_accept_ctrl #(.LVL_W(3)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .irqLevel  (irqLevel),
    .priMask   (priMask),
    .busReady  (busReady),
    .stackDone (stackDone),
    .strb      (strb),
    .busReq    (busReq),
    .stackReq  (stackReq),
    .pcLoad    (pcLoad)
  );

  irq_accept_dpath #(.ADDR_W(24), .DATA_W(32), .LVL_W(3), .VNUM_W(8)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .srWe      (srWe),
    .srSuper   (srSuper),
    .srMask    (srMask),
    .vbrWe     (vbrWe),
    .vbrWdata  (vbrWdata),
    .busRdata  (busRdata),
    .busAddr   (busAddr),
    .pcValue   (pcValue),
    .superMode (superMode),
    .priMask   (priMask)
  );

endmodule

// File: rtl/irq_accept_unit_chk.sv
module irq_accept_unit_chk #(
  parameter int ADDR_W = 24,
  parameter int LVL_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busReady,
  input logic [ADDR_W-1:0] busAddr,
  input logic              stackReq,
  input logic              pcLoad,
  input logic              superMode,
  input logic [LVL_W-1:0]  priMask
);

  // R9: a pending read keeps its request and address
  a_r9_bus_hold: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busReady |=> busReq && $stable(busAddr));

  // R8: bus read and save request never overlap
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(busReq && stackReq));

  // R8: program counter load lasts one cycle
  a_r8_pcload_single: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !pcLoad);

  // R7: saving happens in supervisor mode
  a_r7_stack_super: assert property (@(posedge clk) disable iff (!rstN)
    stackReq |-> superMode);

  // R5: acknowledge read targets the top word of the accepted level
  a_r5_ack_addr: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) && !$past(stackReq) |->
      (&busAddr[ADDR_W-1:LVL_W+1]) && !busAddr[0] &&
      (busAddr[LVL_W:1] == priMask) && (priMask != '0));

  // R3 / R4: an acceptance raises the mask, unless it is the top level
  a_r3_mask_rises: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) && !$past(stackReq) |->
      (priMask > $past(priMask)) || (&priMask));

endmodule

bind irq_accept_unit irq_accept_unit_chk #(.ADDR_W(24), .LVL_W(3)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busReq    (busReq),
  .busReady  (busReady),
  .busAddr   (busAddr),
  .stackReq  (stackReq),
  .pcLoad    (pcLoad),
  .superMode (superMode),
  .priMask   (priMask)
);

// File: tb/tb_irq_accept_unit.sv
module tb_irq_accept_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  irqLevel = '0;
  logic        srWe = 1'b0, srSuper = 1'b0;
  logic [2:0]  srMask = '0;
  logic        vbrWe = 1'b0;
  logic [23:0] vbrWdata = '0;
  logic        busReq;
  logic [23:0] busAddr;
  logic [31:0] busRdata = '0;
  logic        busReady = 1'b0;
  logic        stackReq;
  logic        stackDone = 1'b0;
  logic        pcLoad;
  logic [31:0] pcValue;
  logic        superMode;
  logic [2:0]  priMask;

  int nChecks = 0;
  int nFails  = 0;
  logic [23:0] vbrExp = '0;

  irq_accept_unit dut (.*);

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] ackAddrOf(input int lvl);
    return {20'hFFFFF, lvl[2:0], 1'b0};
  endfunction

  function automatic logic [7:0] vecNumOf(input int lvl);
    return 8'(24 + lvl);
  endfunction

  function automatic logic [31:0] handlerOf(input logic [23:0] a);
    return {8'h5A, a};
  endfunction

  task automatic setSr(input logic s, input logic [2:0] m);
    @(negedge clk); srWe = 1'b1; srSuper = s; srMask = m;
    @(negedge clk); srWe = 1'b0;
  endtask

  // level already driven at the current negedge; serve a full sequence
  task automatic runIrq(input int lvl, input int waits);
    int lat = 0;
    logic [23:0] vaddr;
    vaddr = vbrExp + {14'd0, vecNumOf(lvl), 2'b00};
    while (!busReq && lat < 12) begin
      @(negedge clk); lat++;
    end
    check("R2 latency", lat, 3);
    check("R5 ack addr", {8'd0, busAddr}, {8'd0, ackAddrOf(lvl)});
    check("R7 mask", {29'd0, priMask}, lvl);
    check("R7 super", {31'd0, superMode}, 1);
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      check("R9 hold", {7'd0, busReq, busAddr}, {7'd0, 1'b1, ackAddrOf(lvl)});
    end
    busReady = 1'b1; busRdata = {16'hDEAD, 8'hC3, vecNumOf(lvl)};
    @(negedge clk);
    busReady = 1'b0;
    check("R8 stack", {30'd0, stackReq, busReq}, 32'd2);
    srWe = 1'b1; srSuper = 1'b0; srMask = 3'd0;
    @(negedge clk);
    srWe = 1'b0;
    check("R8 stack wait", {31'd0, stackReq}, 1);
    stackDone = 1'b1;
    @(negedge clk);
    stackDone = 1'b0;
    check("R6 vec addr", {7'd0, busReq, busAddr}, {7'd0, 1'b1, vaddr});
    busReady = 1'b1; busRdata = handlerOf(vaddr);
    @(negedge clk);
    busReady = 1'b0;
    check("R8 pcLoad", {31'd0, pcLoad}, 1);
    check("R8 pcValue", pcValue, handlerOf(vaddr));
    check("R11 busy sr write", {28'd0, superMode, priMask}, {28'd0, 1'b1, lvl[2:0]});
    @(negedge clk);
    check("R8 pcLoad single", {30'd0, pcLoad, busReq}, 0);
  endtask

  task automatic expectIgnored(input string req, input logic [2:0] m, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      check(req, {31'd0, busReq}, 0);
    end
    check(req, {29'd0, priMask}, {29'd0, m});
  endtask

  task automatic dropLevel();
    @(negedge clk); irqLevel = 3'd0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 super", {31'd0, superMode}, 1);
    check("R1 mask", {29'd0, priMask}, 7);
    check("R1 idle", {29'd0, busReq, stackReq, pcLoad}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R10: base write ignored in user mode
    setSr(1'b0, 3'd0);
    @(negedge clk); vbrWe = 1'b1; vbrWdata = 24'h004000;
    @(negedge clk); vbrWe = 1'b0;
    irqLevel = 3'd3;
    runIrq(3, 1);  // R10 base still zero
    dropLevel();
    // R10: base write taken in supervisor mode
    @(negedge clk); vbrWe = 1'b1; vbrWdata = 24'h012300;
    @(negedge clk); vbrWe = 1'b0; vbrExp = 24'h012300;

    // R3 full sweep of mask and level
    for (int m = 0; m < 8; m++) begin
      for (int l = 1; l < 8; l++) begin
        setSr(1'b0, 3'(m));
        irqLevel = 3'(l);
        if (l > m || l == 7) runIrq(l, (l + m) % 3);
        else expectIgnored("R3 masked", 3'(m), 6);
        dropLevel();
      end
    end

    // R3: level zero never accepted
    setSr(1'b0, 3'd0);
    irqLevel = 3'd0;
    expectIgnored("R3 level zero", 3'd0, 6);

    // R4: held top level accepted once, again after a drop
    irqLevel = 3'd7;
    runIrq(7, 0);
    setSr(1'b0, 3'd0);
    expectIgnored("R4 held nmi", 3'd0, 8);
    dropLevel();
    irqLevel = 3'd7;
    runIrq(7, 2);
    dropLevel();

    // R2: level toggling every cycle is never accepted
    setSr(1'b0, 3'd0);
    for (int g = 0; g < 10; g++) begin
      irqLevel = (g % 2 == 0) ? 3'd2 : 3'd5;
      @(negedge clk);
      check("R2 glitch", {31'd0, busReq}, 0);
    end
    irqLevel = 3'd6;
    runIrq(6, 0);
    dropLevel();

    // R6: offset wraps modulo the address width
    @(negedge clk); vbrWe = 1'b1; vbrWdata = 24'hFFFFC0;
    @(negedge clk); vbrWe = 1'b0; vbrExp = 24'hFFFFC0;
    setSr(1'b0, 3'd1);
    irqLevel = 3'd4;
    runIrq(4, 1);
    dropLevel();

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule